// File: doc/BRIEF.md
# Ring-Carry Dual-Lane Ones-Complement Accumulator

This block sits beside a 32-bit data bus and sums the words that cross it while a transfer is in progress. Each bus word is split into two 16-bit half-words. Each half goes into its own ones-complement accumulator lane: bits 15:0 sum the low half-words, and bits 31:16 sum the high half-words. Software or a later stage folds the two lanes together and inverts the result to get a checksum. That folding step is not part of this block.

Carries are not resolved within a single clock. Each lane is cut into small adder groups whose widths are 3, 3, 2, 3, 3 and 2 bits, counting up from the lane's bit 0. The carry out of each group is held in a one-bit register, and on the next clock that register feeds the lowest bit of the group above. The carry register of a lane's top group feeds back into that same lane's bit 0. This end-around path makes the adder a ring, so the lane performs ones-complement addition. Because of this the block can accept one word on every clock. A clock with no add request sums zero into the lanes, so any carries still in flight keep moving until they drain. A settled flag reports when no carry is pending and no add is under way.

The input latch is transparent. While the strobe is high, the operand is taken straight from the bus and is also captured into the latch. While the strobe is low, the latch keeps its contents and supplies them as the operand. There is no separate load path. To preload a value, clear the block and then add that value as data.

Top module: `csum_ring_acc`

## Requirements
- R1: The two 16-bit lanes are independent. Lane 0 (bits 15:0) accumulates the ones-complement sum of the low half-words of the added words, and lane 1 (bits 31:16) does the same for the high half-words. No carry passes between the lanes.
- R2: While `clr` is high at a clock edge, that edge zeroes the accumulator, all twelve carry registers and the input latch.
- R3: A starting value is loaded by clearing the block and then adding the value as an ordinary data word. Once settled, the accumulator reads back that value exactly.
- R4: When `latch_stb` is high, the operand comes from `din` and `din` is captured into the latch. When `latch_stb` is low, the latch holds its value and the held value is the operand. A word that is strobed while `add_en` is low is therefore added by a later add that has no strobe.
- R5: On a clock where `add_en` is low, zero is summed into the lanes. If no carry is pending, the accumulator does not change, whatever `din` and `latch_stb` do.
- R6: A carry out of a group reaches the next group one clock later. Example: after clear, adding 0x00000001 and then 0x00000007 leaves the accumulator at 0x00000000 right after the second add, and at 0x00000008 one idle clock later.
- R7: The top group of each lane feeds its carry to bit 0 of the same lane. Example: after clear, adding 0xFFFFFFFF and then 0x00010001 leaves the accumulator at 0x00000000 with the flag low for five idle clocks, and at 0x00010001 on the sixth idle clock.
- R8: With `latch_stb` and `add_en` high together, one bus word is accumulated on every clock, with no gap needed between words.
- R9: `settled` is high exactly when all carry registers are zero and `add_en` is low. It rises within 16 idle clocks after the last add. Once it is high, each lane is congruent, modulo 0xFFFF, to the ones-complement sum of that lane's data.
- R10: `sum_out` equals the accumulator while `oe` is high, and is 0x00000000 while `oe` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the latch, the accumulator and the carry ring |
| clr | input | 1 | Synchronous clear of the accumulator, the carries and the latch |
| latch_stb | input | 1 | Takes the operand from `din` and captures `din` into the latch |
| add_en | input | 1 | Adds the operand this clock; when low, zero is added |
| oe | input | 1 | Read enable for `sum_out` |
| din | input | 32 | Snooped bus word |
| sum_out | output | 32 | Two lane sums {lane1, lane0} when `oe` is high, otherwise zero |
| settled | output | 1 | No pending carry and no add in the current cycle |

## Verification
The checker runs on every cycle and covers the following: the clear empties every register, the latch holds when not strobed, a quiet accumulator stays put while idle, a lane with no pending carry is stable during idle clocks regardless of the other lane, and the read gate. Whether the settled sums are arithmetically correct, the exact clock on which a carry crosses a group or wraps around, and the preload through an ordinary add can only be shown by the bench's scenarios. In those scenarios, random word streams with gaps and strobe-only or add-only cycles are compared against a ones-complement model.

// File: rtl/csum_ring_acc.sv
module csum_ring_acc (
  input  logic        clk,
  input  logic        clr,
  input  logic        latch_stb,
  input  logic        add_en,
  input  logic        oe,
  input  logic [31:0] din,
  output logic [31:0] sum_out,
  output logic        settled
);
  localparam int LANES = 2;
  localparam int GRPS  = 6;

  function automatic int grp_lo(input int g);
    case (g)
      0: return 0;
      1: return 3;
      2: return 6;
      3: return 8;
      4: return 11;
      default: return 14;
    endcase
  endfunction

  function automatic int grp_w(input int g);
    return (g == 2 || g == 5) ? 2 : 3;
  endfunction

  logic [31:0]            dl, acc, acc_nx, op;
  logic [LANES*GRPS-1:0]  cy, cy_nx;

  assign op = add_en ? (latch_stb ? din : dl) : '0;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    for (genvar g = 0; g < GRPS; g++) begin : g_grp
      localparam int LO   = l*16 + grp_lo(g);
      localparam int W    = grp_w(g);
      localparam int PREV = l*GRPS + (g + GRPS - 1) % GRPS;
      logic [W:0] s;
      assign s = {1'b0, acc[LO +: W]} + {1'b0, op[LO +: W]} + {{W{1'b0}}, cy[PREV]};
      assign acc_nx[LO +: W]   = s[W-1:0];
      assign cy_nx[l*GRPS + g] = s[W];
    end
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      dl  <= '0;
      acc <= '0;
      cy  <= '0;
    end else begin
      if (latch_stb) dl <= din;
      acc <= acc_nx;
      cy  <= cy_nx;
    end
  end

  assign settled = (cy == '0) && !add_en;
  assign sum_out = oe ? acc : '0;
endmodule

module csum_ring_acc_chk (
  input logic        clk,
  input logic        clr,
  input logic        latch_stb,
  input logic        add_en,
  input logic        oe,
  input logic [31:0] sum_out,
  input logic [31:0] acc,
  input logic [31:0] dl,
  input logic [11:0] cy
);
  AST_CLEAR_EMPTIES: assert property (@(posedge clk)
    clr |=> (acc == '0 && cy == '0 && dl == '0)); // R2

  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (clr)
    !latch_stb |=> dl == $past(dl)); // R4

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (clr)
    (!add_en && cy == '0) |=> (acc == $past(acc) && cy == '0)); // R5

  AST_LANE0_ISOLATED: assert property (@(posedge clk) disable iff (clr)
    (!add_en && cy[5:0] == '0) |=> acc[15:0] == $past(acc[15:0])); // R1

  AST_LANE1_ISOLATED: assert property (@(posedge clk) disable iff (clr)
    (!add_en && cy[11:6] == '0) |=> acc[31:16] == $past(acc[31:16])); // R1

  AST_READ_GATE: assert property (@(posedge clk) disable iff (clr)
    sum_out == (oe ? acc : 32'h0)); // R10
endmodule

bind csum_ring_acc csum_ring_acc_chk u_chk (
  .clk(clk), .clr(clr), .latch_stb(latch_stb), .add_en(add_en), .oe(oe),
  .sum_out(sum_out), .acc(acc), .dl(dl), .cy(cy)
);

// File: tb/tb_csum_ring_acc.sv
module tb_csum_ring_acc;
  logic        clk = 0, clr = 1, latch_stb = 0, add_en = 0, oe = 1;
  logic [31:0] din = '0;
  logic [31:0] sum_out;
  logic        settled;
  int          nchk = 0, nerr = 0;
  bit          done = 0;

  csum_ring_acc dut (.clk(clk), .clr(clr), .latch_stb(latch_stb), .add_en(add_en),
                     .oe(oe), .din(din), .sum_out(sum_out), .settled(settled));

  always #5 clk = ~clk;

  function automatic logic [15:0] oadd(input logic [15:0] a, input logic [15:0] b);
    logic [16:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[15:0] + {15'b0, s[16]};
  endfunction

  function automatic logic [15:0] norm(input logic [15:0] x);
    return (x == 16'hFFFF) ? 16'h0000 : x;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic s, input logic a, input logic [31:0] d);
    latch_stb = s; add_en = a; din = d;
    @(negedge clk);
  endtask

  task automatic do_clear();
    clr = 1;
    drive(0, 0, 32'h0);
    clr = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, 0, $urandom);
  endtask

  logic [15:0] m0, m1;
  logic [31:0] mlatch, w;
  int          k;

  initial begin
    void'($urandom(32'h1D5E_77A1));
    do_clear(); do_clear();
    chk("R2 clear zeroes sum", sum_out, 32'h0);
    chk("R9 settled after clear", {31'b0, settled}, 32'h1);

    // R6 carry crosses a group one clock late
    do_clear();
    drive(1, 1, 32'h0000_0001);
    drive(1, 1, 32'h0000_0007);
    chk("R6 carry still pending", sum_out, 32'h0000_0000);
    drive(0, 0, 32'h0);
    chk("R6 carry landed", sum_out, 32'h0000_0008);

    // R7 end-around wrap through the whole ring
    do_clear();
    drive(1, 1, 32'hFFFF_FFFF);
    drive(1, 1, 32'h0001_0001);
    idle(5);
    chk("R7 wrap in flight", sum_out, 32'h0000_0000);
    chk("R7 not settled yet", {31'b0, settled}, 32'h0);
    idle(1);
    chk("R7 wrapped to bit 0", sum_out, 32'h0001_0001);
    chk("R9 settled after wrap", {31'b0, settled}, 32'h1);

    // R3 preload by clear plus add
    do_clear();
    drive(1, 1, 32'h1234_ABCD);
    idle(2);
    chk("R3 preload value", sum_out, 32'h1234_ABCD);

    // R4 strobe-only then add-only uses latched word
    do_clear();
    drive(1, 0, 32'h0005_0003);
    chk("R4 strobe alone adds nothing", sum_out, 32'h0);
    drive(0, 1, 32'hFFFF_FFFF);
    idle(2);
    chk("R4 latched word added", sum_out, 32'h0005_0003);

    // R5 idle clocks with bus activity leave sum alone
    for (int i = 0; i < 6; i++) drive(i[0], 0, $urandom);
    chk("R5 idle keeps sum", sum_out, 32'h0005_0003);

    // R10 read gate
    oe = 0; #1;
    chk("R10 oe low gives zero", sum_out, 32'h0);
    oe = 1; #1;
    chk("R10 oe high gives sum", sum_out, 32'h0005_0003);

    // R8 back-to-back words, R1 lane independence
    do_clear();
    m0 = 0; m1 = 0;
    for (int i = 0; i < 20; i++) begin
      w = $urandom;
      m0 = oadd(m0, w[15:0]); m1 = oadd(m1, w[31:16]);
      drive(1, 1, w);
    end
    idle(16);
    chk("R8 streamed lane0", {16'h0, norm(sum_out[15:0])}, {16'h0, norm(m0)});
    chk("R8 streamed lane1", {16'h0, norm(sum_out[31:16])}, {16'h0, norm(m1)});

    // random streams with gaps and latch modes (R1, R4, R9)
    for (int p = 0; p < 30; p++) begin
      do_clear();
      m0 = 0; m1 = 0; mlatch = 0;
      for (int i = 0; i < 1 + int'($urandom_range(39)); i++) begin
        w = $urandom;
        case ($urandom_range(3))
          0: drive(0, 0, w);
          1: begin mlatch = w; m0 = oadd(m0, w[15:0]); m1 = oadd(m1, w[31:16]); drive(1, 1, w); end
          2: begin mlatch = w; drive(1, 0, w); end
          default: begin m0 = oadd(m0, mlatch[15:0]); m1 = oadd(m1, mlatch[31:16]); drive(0, 1, w); end
        endcase
      end
      k = 0;
      drive(0, 0, $urandom);
      while (!settled && k < 16) begin drive(0, 0, $urandom); k++; end
      chk("R9 settles within 16 idle clocks", {31'b0, settled}, 32'h1);
      chk("R1 lane0 ones-complement sum", {16'h0, norm(sum_out[15:0])}, {16'h0, norm(m0)});
      chk("R1 lane1 ones-complement sum", {16'h0, norm(sum_out[31:16])}, {16'h0, norm(m1)});
    end

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1;
      nchk++; nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end
endmodule